// File: doc/BRIEF.md
# Predicated Saturating Vector Shift Unit

This block shifts every active unsigned lane of a packed vector left by an immediate amount. Any lane whose shifted value does not fit is clamped to all ones. The lane width and the shift distance come from one 7-bit immediate. Its upper four bits form a size selector in thermometer style, and the whole field minus the lane width gives the shift. The result replaces the operand: lanes the predicate leaves inactive come back exactly as they went in.

A caller presents the operand, a predicate with one bit per byte of the vector, and the immediate, together with a valid strobe. One cycle later the registered result appears with its own valid, along with a flag that marks a reserved size selector. The vector width is a parameter that must be a multiple of 128 bits.

Top module: `vsat_shift_unit`

## Requirements
- R1: The size selector is imm_i[6:3]. Pattern 0001 selects 8-bit lanes, 001x selects 16-bit lanes, 01xx selects 32-bit lanes and 1xxx selects 64-bit lanes. imm_i[2:0] are low shift bits.
- R2: The shift distance is the unsigned value of imm_i[6:0] minus the selected lane width in bits. The range is 0 to width-1.
- R3: An active lane whose value survives the shift unchanged in its upper bits yields the element shifted left with zero fill, truncated to the lane width.
- R4: An active lane loses a nonzero bit when it is shifted past the lane's top. Such a lane yields all ones (2^N-1). An all-ones operand therefore always yields all ones.
- R5: Lane k is active when pred_i[k*N/8] is 1, where N is the lane width. An inactive lane returns its operand value. Predicate bits at other byte positions of a lane have no effect.
- R6: A size selector of 0000 is reserved. It sets undef_o and returns vec_i unmodified, whatever the predicate and imm_i[2:0].
- R7: valid_o is valid_i delayed by one clock. vec_o and undef_o belong to the operation accepted on the previous clock.
- R8: While valid_i is low, vec_o and undef_o hold their last values.
- R9: While rst_ni is low, valid_o, undef_o and vec_o are 0.
- R10: The vector holds VEC_W/N lanes, with lane 0 in the least significant bits. Every lane is processed independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Operation strobe |
| vec_i | input | VEC_W | Source vector |
| pred_i | input | VEC_W/8 | Per-byte predicate |
| imm_i | input | 7 | Size selector [6:3] and low shift bits [2:0] |
| valid_o | output | 1 | Result valid |
| vec_o | output | VEC_W | Result vector |
| undef_o | output | 1 | Reserved size selector seen |

## Verification
The hardest case is the edge between clamping and plain shifting. A lane saturates only when a single 1 sits in the top `shift` bits. Random operands almost always saturate once the shift is large, so this edge is seldom reached by chance. The stimulus therefore builds operands with one set bit placed just inside and just outside the surviving range, for every lane width at the smallest and largest shifts. It also drives predicates whose set bits fall only on the non-lowest bytes of each lane, so that every lane is inactive even though the mask is nonzero.

// File: rtl/vsat_pkg.sv
package vsat_pkg;
  typedef enum logic [1:0] {LW8 = 2'd0, LW16 = 2'd1, LW32 = 2'd2, LW64 = 2'd3} lane_w_e;

  localparam int unsigned NUM_WIDTHS = 4;
  localparam int unsigned SHAMT_W    = 6;
  localparam int unsigned IMM_W      = 7;

  function automatic logic [IMM_W-1:0] lane_bits(lane_w_e w);
    return IMM_W'(8) << w;
  endfunction
endpackage

// File: rtl/vsat_decode.sv
module vsat_decode
  import vsat_pkg::*;
(
  input  logic [IMM_W-1:0]   imm_i,
  output lane_w_e            width_o,
  output logic [SHAMT_W-1:0] shamt_o,
  output logic               reserved_o
);
  logic [3:0]       sel;
  logic [IMM_W-1:0] diff;

  assign sel = imm_i[6:3];

  always_comb begin
    reserved_o = 1'b0;
    width_o    = LW8;
    casez (sel)
      4'b1???: width_o = LW64;
      4'b01??: width_o = LW32;
      4'b001?: width_o = LW16;
      4'b0001: width_o = LW8;
      default: reserved_o = 1'b1;
    endcase
  end

  // the thermometer selector guarantees diff < lane width
  assign diff    = imm_i - lane_bits(width_o);
  assign shamt_o = diff[SHAMT_W-1:0];
endmodule

// File: rtl/vsat_lane.sv
module vsat_lane #(
  parameter int unsigned EW      = 8,
  parameter int unsigned SHAMT_W = 6
) (
  input  logic [EW-1:0]      elem_i,
  input  logic [SHAMT_W-1:0] shamt_i,
  input  logic               active_i,
  output logic [EW-1:0]      res_o
);
  localparam int unsigned WIDE = 2 * EW;

  logic [WIDE-1:0] wide;
  logic            sat;

  assign wide = {{EW{1'b0}}, elem_i} << shamt_i;
  assign sat  = |wide[WIDE-1:EW];

  always_comb begin
    if (!active_i)  res_o = elem_i;
    else if (sat)   res_o = {EW{1'b1}};
    else            res_o = wide[EW-1:0];
  end
endmodule

// File: rtl/vsat_width_path.sv
module vsat_width_path #(
  parameter int unsigned VEC_W   = 256,
  parameter int unsigned EW      = 8,
  parameter int unsigned SHAMT_W = 6
) (
  input  logic [VEC_W-1:0]   vec_i,
  input  logic [VEC_W/8-1:0] pred_i,
  input  logic [SHAMT_W-1:0] shamt_i,
  output logic [VEC_W-1:0]   res_o
);
  localparam int unsigned LANES   = VEC_W / EW;
  localparam int unsigned PSTRIDE = EW / 8;

  logic unused_pred;
  assign unused_pred = ^pred_i;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    vsat_lane #(.EW(EW), .SHAMT_W(SHAMT_W)) i_lane (
      .elem_i  (vec_i[l*EW +: EW]),
      .shamt_i (shamt_i),
      .active_i(pred_i[l*PSTRIDE]),
      .res_o   (res_o[l*EW +: EW])
    );
  end
endmodule

// File: rtl/vsat_shift_unit.sv
module vsat_shift_unit
  import vsat_pkg::*;
#(
  parameter int unsigned VEC_W = 256
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [VEC_W-1:0]   vec_i,
  input  logic [VEC_W/8-1:0] pred_i,
  input  logic [6:0]         imm_i,
  output logic               valid_o,
  output logic [VEC_W-1:0]   vec_o,
  output logic               undef_o
);
  localparam int unsigned PRED_W = VEC_W / 8;

  lane_w_e              width;
  logic [SHAMT_W-1:0]   shamt;
  logic                 reserved;
  logic [VEC_W-1:0]     path_res [NUM_WIDTHS];
  logic [VEC_W-1:0]     res_d;

  vsat_decode i_decode (
    .imm_i     (imm_i),
    .width_o   (width),
    .shamt_o   (shamt),
    .reserved_o(reserved)
  );

  for (genvar w = 0; w < NUM_WIDTHS; w++) begin : g_width
    vsat_width_path #(.VEC_W(VEC_W), .EW(8 << w), .SHAMT_W(SHAMT_W)) i_path (
      .vec_i  (vec_i),
      .pred_i (pred_i[PRED_W-1:0]),
      .shamt_i(shamt),
      .res_o  (path_res[w])
    );
  end

  assign res_d = reserved ? vec_i : path_res[width];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      vec_o   <= '0;
      undef_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        vec_o   <= res_d;
        undef_o <= reserved;
      end
    end
  end
endmodule

// File: rtl/vsat_shift_unit_chk.sv
module vsat_shift_unit_chk #(
  parameter int unsigned VEC_W = 256
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               valid_i,
  input logic [VEC_W-1:0]   vec_i,
  input logic [VEC_W/8-1:0] pred_i,
  input logic [6:0]         imm_i,
  input logic               valid_o,
  input logic [VEC_W-1:0]   vec_o,
  input logic               undef_o
);
  // R7
  valid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  // R7
  valid_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  // R8
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(vec_o) && $stable(undef_o)));
  // R6
  reserved_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && imm_i[6:3] == 4'b0000) |=> (undef_o && vec_o == $past(vec_i)));
  // R1
  legal_size_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && imm_i[6:3] != 4'b0000) |=> !undef_o);
  // R5
  no_pred_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && pred_i == '0) |=> (vec_o == $past(vec_i)));
  // R4
  ones_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && &vec_i) |=> (&vec_o));
  // R3
  zero_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && imm_i == 7'd8) |=> (vec_o == $past(vec_i)));
endmodule

bind vsat_shift_unit vsat_shift_unit_chk #(.VEC_W(VEC_W)) i_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .valid_i(valid_i),
  .vec_i  (vec_i),
  .pred_i (pred_i),
  .imm_i  (imm_i),
  .valid_o(valid_o),
  .vec_o  (vec_o),
  .undef_o(undef_o)
);

// File: tb/test_vsat_shift_unit.sv
`timescale 1ns/1ps
module test_vsat_shift_unit;
  localparam int VW = 256;
  localparam int PW = VW / 8;

  logic          clk_i = 1'b0;
  logic          rst_ni;
  logic          valid_i;
  logic [VW-1:0] vec_i;
  logic [PW-1:0] pred_i;
  logic [6:0]    imm_i;
  logic          valid_o;
  logic [VW-1:0] vec_o;
  logic          undef_o;

  int checks = 0;
  int errors = 0;
  string cur_tag = "R9";
  string exp_tag = "R9";
  logic          exp_valid = 1'b0;
  logic [VW-1:0] exp_vec = '0;
  logic          exp_undef = 1'b0;

  always #2.5 clk_i = ~clk_i;

  vsat_shift_unit #(.VEC_W(VW)) i_vsat_shift_unit (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .vec_i(vec_i),
    .pred_i(pred_i), .imm_i(imm_i), .valid_o(valid_o), .vec_o(vec_o),
    .undef_o(undef_o)
  );

  function automatic logic [VW-1:0] model(input logic [VW-1:0] v, input logic [PW-1:0] p,
                                          input logic [6:0] imm, output logic und);
    logic [VW-1:0] r;
    int ew, sh;
    r = v;
    und = 1'b0;
    if (imm[6:3] == 4'd0) begin
      und = 1'b1;
      return v;
    end
    if (imm[6]) ew = 64; else if (imm[5]) ew = 32; else if (imm[4]) ew = 16; else ew = 8;
    sh = int'(imm) - ew;
    for (int k = 0; k < VW / ew; k++) begin
      logic [63:0] el, mx, lim, o;
      if (!p[k*ew/8]) continue;
      el = '0;
      for (int b = 0; b < ew; b++) el[b] = v[k*ew+b];
      mx = (ew == 64) ? {64{1'b1}} : ((64'd1 << ew) - 64'd1);
      lim = mx >> sh;
      o = (el > lim) ? mx : ((el << sh) & mx);
      for (int b = 0; b < ew; b++) r[k*ew+b] = o[b];
    end
    return r;
  endfunction

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      exp_valid = 1'b0; exp_vec = '0; exp_undef = 1'b0; exp_tag = "R9";
    end else begin
      exp_valid = valid_i;
      if (valid_i) begin
        exp_vec = model(vec_i, pred_i, imm_i, exp_undef);
        exp_tag = cur_tag;
      end
    end
    #1;
    checks++;
    if (valid_o !== exp_valid || vec_o !== exp_vec || undef_o !== exp_undef) begin
      errors++;
      $display("FAIL %s valid=%b/%b undef=%b/%b vec=%h exp=%h",
               exp_tag, valid_o, exp_valid, undef_o, exp_undef, vec_o, exp_vec);
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  function automatic logic [VW-1:0] rnd_vec();
    logic [VW-1:0] v;
    for (int i = 0; i < VW / 32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic op(input logic [6:0] imm, input logic [VW-1:0] v,
                    input logic [PW-1:0] p, input string tag);
    @(negedge clk_i);
    valid_i = 1'b1; imm_i = imm; vec_i = v; pred_i = p; cur_tag = tag;
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      valid_i = 1'b0; vec_i = rnd_vec(); imm_i = 7'($urandom); pred_i = '0; cur_tag = tag;
    end
  endtask

  // one set bit per lane at position pos
  function automatic logic [VW-1:0] bit_vec(input int ew, input int pos);
    logic [VW-1:0] v;
    v = '0;
    for (int k = 0; k < VW / ew; k++) v[k*ew + pos] = 1'b1;
    return v;
  endfunction

  initial begin
    int sh_list[4];
    rst_ni = 1'b0; valid_i = 1'b0; vec_i = '0; pred_i = '0; imm_i = '0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;

    // R1 R2 R10: every width, several shifts, random data
    for (int w = 0; w < 4; w++) begin
      int ew;
      ew = 8 << w;
      sh_list = '{0, 1, ew / 2, ew - 1};
      foreach (sh_list[j]) begin
        op(7'(ew + sh_list[j]), rnd_vec(), '1, "R1");
        op(7'(ew + sh_list[j]), rnd_vec() >> (VW / 2), '1, "R2");
      end
      // R3/R4 boundary: single bit just inside and just outside range
      for (int s = 1; s < ew; s += (ew / 4 > 0 ? ew / 4 : 1)) begin
        op(7'(ew + s), bit_vec(ew, ew - 1 - s), '1, "R3");
        op(7'(ew + s), bit_vec(ew, ew - s), '1, "R4");
      end
      op(7'(ew + ew - 1), bit_vec(ew, 0), '1, "R3");
      op(7'(ew + ew - 1), bit_vec(ew, 1), '1, "R4");
      op(7'(ew + 3), '1, 32'($urandom), "R4");
      // R5: predicate only on non-lowest bytes of each lane
      if (ew > 8) begin
        logic [PW-1:0] p;
        p = '1;
        for (int k = 0; k < VW / ew; k++) p[k*ew/8] = 1'b0;
        op(7'(ew + 1), rnd_vec(), p, "R5");
      end
      op(7'(ew + 2), rnd_vec(), 32'($urandom), "R5");
      // R10: distinct lane values
      begin
        logic [VW-1:0] v;
        v = '0;
        for (int k = 0; k < VW / ew; k++) v[k*ew +: 8] = 8'(k + 1);
        op(7'(ew + 1), v, 32'h5555_5555, "R10");
      end
    end

    // R6: reserved selector with every low field
    for (int i = 0; i < 8; i++) op(7'(i), rnd_vec(), 32'($urandom), "R6");

    // R7 R8: gaps between operations
    op(7'd12, rnd_vec(), '1, "R7");
    idle(4, "R8");
    op(7'd0, rnd_vec(), '1, "R7");
    idle(3, "R8");

    // random mix
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 4) == 0) idle(1, "R8");
      else op(7'($urandom), rnd_vec(), 32'($urandom), "R10");
    end
    idle(3, "R8");

    // R9: reset mid-stream
    op(7'd9, rnd_vec(), '1, "R9");
    @(negedge clk_i);
    rst_ni = 1'b0; valid_i = 1'b0;
    #1;
    checks++;
    if (valid_o !== 1'b0 || undef_o !== 1'b0 || vec_o !== '0) begin
      errors++;
      $display("FAIL R9 valid=%b undef=%b vec=%h exp=0", valid_o, undef_o, vec_o);
    end
    repeat (2) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;
    idle(2, "R9");
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule